// File: doc/BRIEF.md
# Interrupt Status Register Unit

This unit keeps the three registers that report the state of a storage-bus interface controller to host software: the status byte, the interrupt-cause byte and the sequence-step field. It also drives the controller's single level-sensitive interrupt line. The command engine and the DMA engine send set requests to it, and the host reads it through a plain byte-wide read port.

Reading the interrupt-cause register is destructive. The read returns the value the register held before the read, and at the same clock edge it empties the cause register, drops terminal count, moves the sequence step to 4 and lowers the interrupt line. When a new event request arrives in the same cycle as that read, the new event is kept, so no event is lost between a read and a write. Reads of every other offset leave all state as it was.

Top module: `irq_status_regs`

## Requirements
- R1: After reset the status, interrupt-cause and sequence-step registers read 0 and `irq` is low. Offset 0xE reads the revision code 0x04.
- R2: A `phaseWe` pulse loads `phaseIn` into status bits 2..0 (data-out 0, data-in 1, command 2, status 3, message-out 6, message-in 7). Status is read at offset 4.
- R3: `tcSet`, `peSet` and `geSet` set status bit 4 (terminal count), bit 5 (parity error) and bit 6 (gross error). `tcClr` clears bit 4. Bits 5 and 6 clear only on reset.
- R4: `intrSet` is ORed into the interrupt-cause register (offset 5) through the mask 0xB8: function-complete 0x08, bus-service 0x10, disconnect 0x20, bus-reset 0x80. Set bits outside the mask are dropped.
- R5: `irqRaise` sets status bit 7 and `irq`. `irqLower` clears both. Raising while already set or lowering while already clear changes nothing. `irq` always equals status bit 7. Raise wins over lower.
- R6: A read (`rdEn`) of offset 5 returns the prior cause value in the same cycle. After the edge the cause register is 0, status bit 4 is 0, the sequence step is 4 and `irq` is low. Phase, PE and GE are kept.
- R7: A set request in the same cycle as a clear-on-read wins: `intrSet` bits, `tcSet`, `seqWe` and `irqRaise` take effect over the clear.
- R8: Reads with `rdEn` of any offset other than 5 change no register and do not change `irq`.
- R9: A `seqWe` pulse loads `seqIn` into the sequence-step field. The field is read at offset 6 in bits 2..0, with the upper bits 0.
- R10: Offsets other than 4, 5, 6 and 0xE read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset |
| phaseWe | input | 1 | Load bus phase |
| phaseIn | input | 3 | Bus phase value |
| tcSet | input | 1 | Set terminal count |
| tcClr | input | 1 | Clear terminal count |
| peSet | input | 1 | Set parity error |
| geSet | input | 1 | Set gross error |
| intrSet | input | 8 | Interrupt-cause bits to set |
| seqWe | input | 1 | Load sequence step |
| seqIn | input | 3 | Sequence step value |
| irqRaise | input | 1 | Raise interrupt |
| irqLower | input | 1 | Lower interrupt |
| rdEn | input | 1 | Read strobe (enables side effects) |
| rdAddr | input | 4 | Read offset |
| rdData | output | 8 | Read data for rdAddr, combinational |
| irq | output | 1 | Level interrupt |

## Verification
Every piece of internal state shows at the ports in the cycle after it changes: each register can be read without side effects, and `irq` mirrors status bit 7. A bad update therefore shows up at the next peek, or at once on `irq`. The bench focuses on collisions, where a clear-on-read meets a set of the cause register, terminal count, sequence step or interrupt in the same cycle. In those cases a wrong priority would silently lose an event, and the register would read zero when the model expects the new bit.

// File: rtl/irqstat_pkg.sv
package irqstat_pkg;
  typedef struct packed {
    logic clrOnRead;  // destructive read of the cause register
    logic irqUp;
    logic irqDown;
    logic tcDrop;
  } irqStrobes_t;
endpackage

// File: rtl/irqstat_ctrl.sv
module irqstat_ctrl #(
  parameter int ADDR_W   = 4,
  parameter int INTR_OFS = 5
) (
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              irqRaise,
  input  logic              irqLower,
  input  logic              tcSet,
  input  logic              tcClr,
  output irqstat_pkg::irqStrobes_t strobes
);
  logic rdCause;
  assign rdCause = rdEn && (rdAddr == ADDR_W'(INTR_OFS));

  always_comb begin
    strobes.clrOnRead = rdCause;
    strobes.irqUp     = irqRaise;
    // a set request always beats a clear (R5, R7)
    strobes.irqDown   = (irqLower || rdCause) && !irqRaise;
    strobes.tcDrop    = (tcClr || rdCause) && !tcSet;
  end
endmodule

// File: rtl/irqstat_dp.sv
module irqstat_dp #(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 4,
  parameter int STAT_OFS  = 4,
  parameter int INTR_OFS  = 5,
  parameter int SEQ_OFS   = 6,
  parameter int REV_OFS   = 14,
  parameter int REV_CODE  = 4,
  parameter int SEQ_RD    = 4,
  parameter int INTR_MASK = 8'hB8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  irqstat_pkg::irqStrobes_t strobes,
  input  logic              phaseWe,
  input  logic [2:0]        phaseIn,
  input  logic              tcSet,
  input  logic              peSet,
  input  logic              geSet,
  input  logic [DATA_W-1:0] intrSet,
  input  logic              seqWe,
  input  logic [2:0]        seqIn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  localparam logic [DATA_W-1:0] MASK = DATA_W'(INTR_MASK);

  logic [2:0]        phaseQ;
  logic              tcQ, peQ, geQ, irqQ;
  logic [DATA_W-1:0] intrQ;
  logic [2:0]        seqQ;
  logic [DATA_W-1:0] statusByte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phaseQ <= '0; tcQ <= 1'b0; peQ <= 1'b0; geQ <= 1'b0;
      irqQ <= 1'b0; intrQ <= '0; seqQ <= '0;
    end else begin
      if (phaseWe) phaseQ <= phaseIn;
      if (tcSet) tcQ <= 1'b1;
      else if (strobes.tcDrop) tcQ <= 1'b0;
      if (peSet) peQ <= 1'b1;
      if (geSet) geQ <= 1'b1;
      if (strobes.irqUp) irqQ <= 1'b1;
      else if (strobes.irqDown) irqQ <= 1'b0;
      intrQ <= (strobes.clrOnRead ? '0 : intrQ) | (intrSet & MASK);
      if (seqWe) seqQ <= seqIn;
      else if (strobes.clrOnRead) seqQ <= 3'(SEQ_RD);
    end
  end

  assign statusByte = DATA_W'({irqQ, geQ, peQ, tcQ, 1'b0, phaseQ});
  assign irq = irqQ;

  always_comb begin
    if (rdAddr == ADDR_W'(STAT_OFS))      rdData = statusByte;
    else if (rdAddr == ADDR_W'(INTR_OFS)) rdData = intrQ;
    else if (rdAddr == ADDR_W'(SEQ_OFS))  rdData = DATA_W'(seqQ);
    else if (rdAddr == ADDR_W'(REV_OFS))  rdData = DATA_W'(REV_CODE);
    else                                  rdData = '0;
  end

  // R6: destructive read empties the cause register when nothing new arrives
  a_r6_cause_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.clrOnRead && intrSet == '0) |=> intrQ == '0);
  // R6: sequence step forced after the read unless reloaded
  a_r6_seq_forced: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.clrOnRead && !seqWe) |=> seqQ == 3'(SEQ_RD));
  // R7: a raise collides with the read and still wins
  a_r7_raise_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.clrOnRead && strobes.irqUp) |=> irq);
  // R7: a new cause bit survives a simultaneous read
  a_r7_cause_kept: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.clrOnRead |=> ((intrQ & $past(intrSet & MASK)) == $past(intrSet & MASK)));
  // R3: terminal count set request always lands
  a_r3_tc_set: assert property (@(posedge clk) disable iff (!rst_n)
    tcSet |=> statusByte[4]);
  // R8: no strobes, no cause change
  a_r8_no_side_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobes.clrOnRead && intrSet == '0) |=> $stable(intrQ));
  // R4: bits outside the mask never appear
  a_r4_mask_only: assert property (@(posedge clk) disable iff (!rst_n)
    (intrQ & ~MASK) == '0);
endmodule

// File: rtl/irq_status_regs.sv
module irq_status_regs #(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 4,
  parameter int REV_CODE  = 4,
  parameter int INTR_MASK = 8'hB8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phaseWe,
  input  logic [2:0]        phaseIn,
  input  logic              tcSet,
  input  logic              tcClr,
  input  logic              peSet,
  input  logic              geSet,
  input  logic [DATA_W-1:0] intrSet,
  input  logic              seqWe,
  input  logic [2:0]        seqIn,
  input  logic              irqRaise,
  input  logic              irqLower,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  localparam int INTR_OFS = 5;

  irqstat_pkg::irqStrobes_t strobes;

  irqstat_ctrl #(.ADDR_W(ADDR_W), .INTR_OFS(INTR_OFS)) ctrl_i (
    .rdEn(rdEn), .rdAddr(rdAddr), .irqRaise(irqRaise), .irqLower(irqLower),
    .tcSet(tcSet), .tcClr(tcClr), .strobes(strobes)
  );

  irqstat_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .INTR_OFS(INTR_OFS),
               .REV_CODE(REV_CODE), .INTR_MASK(INTR_MASK)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobes(strobes),
    .phaseWe(phaseWe), .phaseIn(phaseIn), .tcSet(tcSet), .peSet(peSet),
    .geSet(geSet), .intrSet(intrSet), .seqWe(seqWe), .seqIn(seqIn),
    .rdAddr(rdAddr), .rdData(rdData), .irq(irq)
  );
endmodule

// File: tb/irq_status_regs_tb.sv
module irq_status_regs_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic phaseWe = 0, tcSet = 0, tcClr = 0, peSet = 0, geSet = 0;
  logic seqWe = 0, irqRaise = 0, irqLower = 0, rdEn = 0;
  logic [2:0] phaseIn = 0, seqIn = 0;
  logic [7:0] intrSet = 0;
  logic [3:0] rdAddr = 0;
  logic [7:0] rdData;
  logic irq;

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural reference state
  int mPhase, mTc, mPe, mGe, mIrq, mIntr, mSeq;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_regs dut_i (.*);

  function automatic int modelRead(int a);
    case (a)
      4:  return (mIrq << 7) | (mGe << 6) | (mPe << 5) | (mTc << 4) | mPhase;
      5:  return mIntr;
      6:  return mSeq;
      14: return 4;
      default: return 0;
    endcase
  endfunction

  task automatic modelReset();
    mPhase = 0; mTc = 0; mPe = 0; mGe = 0; mIrq = 0; mIntr = 0; mSeq = 0;
  endtask

  task automatic modelStep();
    bit rd5;
    rd5 = rdEn && rdAddr == 5;
    if (phaseWe) mPhase = phaseIn;
    if (tcSet) mTc = 1; else if (tcClr || rd5) mTc = 0;
    if (peSet) mPe = 1;
    if (geSet) mGe = 1;
    if (irqRaise) mIrq = 1; else if (irqLower || rd5) mIrq = 0;
    mIntr = (rd5 ? 0 : mIntr) | (intrSet & 8'hB8);
    if (seqWe) mSeq = seqIn; else if (rd5) mSeq = 4;
  endtask

  task automatic compare(string tag);
    checks++;
    if (rdData !== 8'(modelRead(rdAddr)) || irq !== 1'(mIrq)) begin
      errors++;
      $display("FAIL %s addr=%0h rdData=%02h irq=%0b expected rdData=%02h irq=%0b",
               tag, rdAddr, rdData, irq, modelRead(rdAddr), mIrq);
    end
  endtask

  // compare, clock once, update model, release pulses
  task automatic tick(string tag);
    #1 compare(tag);
    @(posedge clk);
    modelStep();
    @(negedge clk);
    phaseWe = 0; tcSet = 0; tcClr = 0; peSet = 0; geSet = 0; seqWe = 0;
    irqRaise = 0; irqLower = 0; rdEn = 0; intrSet = 0;
  endtask

  task automatic peekAll(string tag);
    foreach (rdAddr[i]) ;
    rdAddr = 4; tick(tag);
    rdAddr = 5; tick(tag);
    rdAddr = 6; tick(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state and revision code
    peekAll("R1");
    rdAddr = 14; tick("R1");
    // R10 unmapped offsets
    for (int a = 0; a < 16; a++) begin
      rdAddr = 4'(a); tick("R10");
    end
    // R2 every phase code
    for (int p = 0; p < 8; p++) begin
      if (p == 4 || p == 5) continue;
      phaseWe = 1; phaseIn = 3'(p); rdAddr = 4; tick("R2");
      tick("R2");
    end
    // R3 error and count bits
    tcSet = 1; peSet = 1; tick("R3");
    geSet = 1; tick("R3");
    tcClr = 1; tick("R3");
    tick("R3");
    // R4 masked cause bits
    rdAddr = 5; intrSet = 8'h47; tick("R4");
    intrSet = 8'h10; tick("R4");
    intrSet = 8'hA0; tick("R4");
    tick("R4");
    // R5 raise and lower, idempotent, raise beats lower
    rdAddr = 4;
    irqRaise = 1; tick("R5");
    irqRaise = 1; tick("R5");
    irqLower = 1; tick("R5");
    irqLower = 1; tick("R5");
    irqRaise = 1; irqLower = 1; tick("R5");
    tick("R5");
    // R9 sequence step
    rdAddr = 6; seqWe = 1; seqIn = 3'd2; tick("R9");
    tick("R9");
    // R8 non-destructive reads of other offsets
    tcSet = 1; tick("R8");
    for (int a = 0; a < 16; a++) begin
      if (a == 5) continue;
      rdAddr = 4'(a); rdEn = 1; tick("R8");
    end
    peekAll("R8");
    // R6 destructive read
    rdAddr = 5; rdEn = 1; tick("R6");
    peekAll("R6");
    // R7 collisions with the destructive read
    intrSet = 8'h08; tick("R7");
    tcSet = 1; irqRaise = 1; tick("R7");
    rdAddr = 5; rdEn = 1; intrSet = 8'h20; tcSet = 1; irqRaise = 1;
    seqWe = 1; seqIn = 3'd1; tick("R7");
    peekAll("R7");
    rdAddr = 5; rdEn = 1; tick("R7");
    peekAll("R7");
    // R1 reset again from a busy state
    irqRaise = 1; intrSet = 8'h80; tick("R1");
    rst_n = 0; modelReset();
    @(negedge clk); rst_n = 1;
    peekAll("R1");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule